// File: doc/BRIEF.md
# Fracturable Lookup Slice with Wide-Function Multiplexers

This block is a logic slice with four six-input lookup tables, called A, B, C and D. Each table holds a 64-bit truth table. A table can produce one function of all six of its inputs. It can also produce two separate five-input functions that share the same five low inputs. Two multiplexers of the first level join the A/B and C/D pairs into seven-input functions. A final multiplexer joins those two results into one eight-input function, so the whole slice can realise any eight-input function.

The truth tables are programmed through a serial port. The bits of a word are shifted in, most significant bit first, while a load-enable is held high. The finished word is copied into the selected table on the first clock edge where the load-enable is seen low again. Until that edge, the old contents stay in force.

All function outputs are pure combinational reads of the stored tables. No pipeline register sits between the inputs and the outputs. The propagation path is the same for every programmed function and for both modes.

Top module: `lut_slice`

## Requirements
- R1: After reset every table holds all zeros, so every O6, O5, seven-input and eight-input output reads 0 whatever the inputs.
- R2: While `cfg_load` is 1, each rising clock edge shifts `cfg_bit` into a staging word, most significant bit first. `cfg_sel` (0=A, 1=B, 2=C, 3=D) as seen on the last shifting edge names the target table. The staged word replaces that table on the first rising edge where `cfg_load` is 0. Before that edge the table keeps its old contents.
- R3: In six-input mode (`mode_dual[t]`=0), `o6[t]` equals bit `lut_in[t]` of table t's word, with `lut_in[t][5]` as the most significant index bit.
- R4: `o5[t]` always equals bit `{0, lut_in[t][4:0]}` of table t's word, which is the lower 32-bit half. It is the same in both modes and does not depend on `lut_in[t][5]`.
- R5: In dual mode (`mode_dual[t]`=1), `o6[t]` equals bit `{1, lut_in[t][4:0]}`, which is the upper 32-bit half. `lut_in[t][5]` has no effect.
- R6: `f7_out[0]` equals `o6[1]` (B) when `f7_sel[0]` is 1 and `o6[0]` (A) otherwise. `f7_out[1]` equals `o6[3]` (D) when `f7_sel[1]` is 1 and `o6[2]` (C) otherwise.
- R7: `f8_out` equals `f7_out[1]` when `f8_sel` is 1 and `f7_out[0]` otherwise. Consider the case where all tables get the same inputs, both `f7_sel` bits equal s7, and the 256-bit function T is stored with A=T[63:0], B=T[127:64], C=T[191:128] and D=T[255:192]. Then `f8_out` equals T[{f8_sel, s7, lut_in}].
- R8: All function outputs follow their inputs within the same clock cycle, with no clock edge in between.
- R9: Loading one table leaves the other three unchanged. If more than 64 bits are shifted in one load, only the last 64 are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration path |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Shift enable; its falling level commits the word |
| cfg_sel | input | 2 | Target table for the word being loaded |
| cfg_bit | input | 1 | Serial configuration data, MSB first |
| lut_in | input | 4x6 | Six select inputs per table, index t = table |
| mode_dual | input | 4 | Per-table dual five-input mode |
| f7_sel | input | 2 | Selects of the two seven-input muxes |
| f8_sel | input | 1 | Select of the eight-input mux |
| o6 | output | 4 | Six-input (or upper-half) result per table |
| o5 | output | 4 | Lower-half five-input result per table |
| f7_out | output | 2 | Seven-input results (A/B, C/D) |
| f8_out | output | 1 | Eight-input result |

## Verification
The only state in the slice is the staging word, the commit flag, the target index and the four stored tables. A wrong bit in any table shows up on `o6`, `o5` or the wide outputs as soon as an input pattern addresses that bit, in the same cycle. The full 256-index sweep therefore exposes any wrongly stored bit within one pass. A commit that lands in the wrong table, comes one edge early or late, or keeps the wrong 64 bits is seen on the first vector that addresses the affected table after the load.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;
    localparam int NUM_LUT = 4;
    localparam int LUT_K   = 6;
    localparam int CFG_W   = 1 << LUT_K;
    localparam int SEL_W   = $clog2(NUM_LUT);
    localparam int NUM_F7  = NUM_LUT / 2;

    typedef struct packed {
        logic [CFG_W-1:0]              shadow;
        logic                          armed;
        logic [SEL_W-1:0]              tgt;
        logic [NUM_LUT-1:0][CFG_W-1:0] tbl;
    } ldr_state_t;
endpackage

// File: rtl/lut_cfg_loader.sv
module lut_cfg_loader
    import lut_slice_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_load,
    input  logic [SEL_W-1:0]              cfg_sel,
    input  logic                          cfg_bit,
    output logic [NUM_LUT-1:0][CFG_W-1:0] tbl_o
);
    ldr_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.armed = cfg_load;
        if (cfg_load) begin
            s_d.shadow = {s_q.shadow[CFG_W-2:0], cfg_bit};
            s_d.tgt    = cfg_sel;
        end
        if (s_q.armed && !cfg_load) begin
            s_d.tbl[s_q.tgt] = s_q.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tbl_o = s_q.tbl;

    // R2: the staged word lands in the latched target on the commit edge
    a_r2_commit_word: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.armed && !cfg_load) |=> (s_q.tbl[$past(s_q.tgt)] == $past(s_q.shadow)));

    // R9: tables do not move except on a commit edge
    a_r9_tables_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.armed && !cfg_load) |=> $stable(s_q.tbl));
endmodule

// File: rtl/lut6_frac.sv
module lut6_frac
    import lut_slice_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [LUT_K-1:0] sel,
    input  logic             dual,
    output logic             o6,
    output logic             o5
);
    logic [LUT_K-1:0] idx_hi;
    logic [LUT_K-1:0] idx_lo;

    always_comb begin
        idx_hi = {(dual | sel[LUT_K-1]), sel[LUT_K-2:0]};
        idx_lo = {1'b0, sel[LUT_K-2:0]};
        o6     = cfg_word[idx_hi];
        o5     = cfg_word[idx_lo];
    end
endmodule

// File: rtl/lut_wide_mux.sv
module lut_wide_mux
    import lut_slice_pkg::*;
(
    input  logic [NUM_LUT-1:0] o6_in,
    input  logic [NUM_F7-1:0]  f7_sel,
    input  logic               f8_sel,
    output logic [NUM_F7-1:0]  f7_out,
    output logic               f8_out
);
    for (genvar p = 0; p < NUM_F7; p++) begin : g_f7
        always_comb begin
            f7_out[p] = f7_sel[p] ? o6_in[2*p+1] : o6_in[2*p];
        end
    end

    always_comb begin
        f8_out = f8_sel ? f7_out[1] : f7_out[0];
    end
endmodule

// File: rtl/lut_slice.sv
module lut_slice
    import lut_slice_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_load,
    input  logic [SEL_W-1:0]              cfg_sel,
    input  logic                          cfg_bit,
    input  logic [NUM_LUT-1:0][LUT_K-1:0] lut_in,
    input  logic [NUM_LUT-1:0]            mode_dual,
    input  logic [NUM_F7-1:0]             f7_sel,
    input  logic                          f8_sel,
    output logic [NUM_LUT-1:0]            o6,
    output logic [NUM_LUT-1:0]            o5,
    output logic [NUM_F7-1:0]             f7_out,
    output logic                          f8_out
);
    logic [NUM_LUT-1:0][CFG_W-1:0] tbl;

    lut_cfg_loader u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_sel  (cfg_sel),
        .cfg_bit  (cfg_bit),
        .tbl_o    (tbl)
    );

    for (genvar t = 0; t < NUM_LUT; t++) begin : g_lut
        lut6_frac u_lut (
            .cfg_word (tbl[t]),
            .sel      (lut_in[t]),
            .dual     (mode_dual[t]),
            .o6       (o6[t]),
            .o5       (o5[t])
        );

        // R5: in dual mode the sixth input cannot move o6
        a_r5_dual_ignores_top: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_dual[t] && $stable(mode_dual[t]) && $stable(tbl[t])
             && $stable(lut_in[t][LUT_K-2:0])) |-> $stable(o6[t]));

        // R4: o5 depends only on the five low inputs and the stored word
        a_r4_o5_mode_free: assert property (@(posedge clk) disable iff (!rst_n)
            ($stable(tbl[t]) && $stable(lut_in[t][LUT_K-2:0])) |-> $stable(o5[t]));
    end

    lut_wide_mux u_wide (
        .o6_in  (o6),
        .f7_sel (f7_sel),
        .f8_sel (f8_sel),
        .f7_out (f7_out),
        .f8_out (f8_out)
    );

    // R6: each seven-input result follows the chosen table of its pair
    a_r6_f7_ab_pick: assert property (@(posedge clk) disable iff (!rst_n)
        f7_sel[0] |-> (f7_out[0] == o6[1]));
    a_r6_f7_cd_pick: assert property (@(posedge clk) disable iff (!rst_n)
        !f7_sel[1] |-> (f7_out[1] == o6[2]));

    // R7: the eight-input result follows the chosen seven-input result
    a_r7_f8_pick: assert property (@(posedge clk) disable iff (!rst_n)
        f8_sel |-> (f8_out == f7_out[1]));
endmodule

// File: tb/lut_slice_tb.sv
module lut_slice_tb;
    localparam int CLK_P = 10;

    typedef struct {
        logic [3:0] o6;
        logic [3:0] o5;
        logic [1:0] f7;
        logic       f8;
        string      req;
    } exp_t;

    logic             clk = 0;
    logic             rst_n = 0;
    logic             cfg_load = 0;
    logic [1:0]       cfg_sel = 0;
    logic             cfg_bit = 0;
    logic [3:0][5:0]  lut_in = '0;
    logic [3:0]       mode_dual = '0;
    logic [1:0]       f7_sel = '0;
    logic             f8_sel = 0;
    logic [3:0]       o6, o5;
    logic [1:0]       f7_out;
    logic             f8_out;

    int applied = 0;
    int fails = 0;
    bit done = 0;
    exp_t q[$];
    logic [63:0] mw [4];

    always #(CLK_P/2) clk = ~clk;

    lut_slice u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_sel(cfg_sel),
        .cfg_bit(cfg_bit), .lut_in(lut_in), .mode_dual(mode_dual),
        .f7_sel(f7_sel), .f8_sel(f8_sel), .o6(o6), .o5(o5),
        .f7_out(f7_out), .f8_out(f8_out)
    );

    function automatic exp_t model();
        exp_t e;
        for (int t = 0; t < 4; t++) begin
            e.o6[t] = mode_dual[t] ? mw[t][{1'b1, lut_in[t][4:0]}] : mw[t][lut_in[t]];
            e.o5[t] = mw[t][{1'b0, lut_in[t][4:0]}];
        end
        e.f7[0] = f7_sel[0] ? e.o6[1] : e.o6[0];
        e.f7[1] = f7_sel[1] ? e.o6[3] : e.o6[2];
        e.f8    = f8_sel ? e.f7[1] : e.f7[0];
        return e;
    endfunction

    // driver: called right after a falling edge, pushes the expected result
    task automatic apply_now(input logic [3:0][5:0] ins, input logic [3:0] dual,
                             input logic [1:0] s7, input logic s8, input string req);
        exp_t e;
        lut_in = ins; mode_dual = dual; f7_sel = s7; f8_sel = s8;
        e = model();
        e.req = req;
        q.push_back(e);
    endtask

    task automatic rand_vec(input logic [3:0] dual, input string req);
        @(negedge clk);
        apply_now({6'($urandom), 6'($urandom), 6'($urandom), 6'($urandom)},
                  dual, 2'($urandom), 1'($urandom), req);
    endtask

    // serial load, MSB first; optional junk bits before and a mid-load check
    task automatic load_word(input logic [1:0] sel, input logic [63:0] w,
                             input int junk, input bit mid_check);
        for (int j = 0; j < junk; j++) begin
            @(negedge clk);
            cfg_load = 1; cfg_sel = sel; cfg_bit = 1'($urandom);
        end
        for (int i = 63; i >= 0; i--) begin
            @(negedge clk);
            cfg_load = 1; cfg_sel = sel; cfg_bit = w[i];
            if (mid_check && i == 32)
                apply_now({6'($urandom), 6'($urandom), 6'($urandom), 6'($urandom)},
                          4'($urandom), 2'($urandom), 1'($urandom), "R2 old word kept mid-load");
        end
        @(negedge clk);
        cfg_load = 0;
        @(posedge clk);
        mw[sel] = w;
    endtask

    // monitor: compares in the same cycle the vector was driven, before the next edge (R8)
    always @(negedge clk) begin
        #3;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            applied++;
            if (o6 !== e.o6 || o5 !== e.o5 || f7_out !== e.f7 || f8_out !== e.f8) begin
                fails++;
                $display("FAIL %s: got o6=%b o5=%b f7=%b f8=%b expected o6=%b o5=%b f7=%b f8=%b",
                         e.req, o6, o5, f7_out, f8_out, e.o6, e.o5, e.f7, e.f8);
            end
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
            $finish;
        end
    end

    initial begin
        logic [255:0] big;
        for (int t = 0; t < 4; t++) mw[t] = '0;
        // R1: reset state, all outputs zero
        for (int k = 0; k < 3; k++) rand_vec(4'($urandom), "R1 reset clears tables");
        @(negedge clk);
        rst_n = 1;
        for (int k = 0; k < 3; k++) rand_vec(4'($urandom), "R1 zero after reset");

        // R2: program all tables
        for (int t = 0; t < 4; t++)
            load_word(2'(t), {$urandom, $urandom}, 0, 0);

        for (int k = 0; k < 40; k++) rand_vec(4'b0000, "R3 R6 R7 R8 six-input mode");
        for (int k = 0; k < 40; k++) rand_vec(4'b1111, "R4 R5 dual mode");
        for (int k = 0; k < 40; k++) rand_vec(4'($urandom), "R4 R5 R3 mixed modes");

        // R5: toggle in6 in dual mode with the rest fixed
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            apply_now({6'h3A ^ {k[0], 5'd0}, 6'h15 ^ {k[1], 5'd0},
                       6'h07 ^ {k[2], 5'd0}, 6'h2C ^ {k[0], 5'd0}},
                      4'b1111, 2'(k), k[2], "R5 in6 ignored");
        end

        // R2: reload A with a mid-load check of the old word
        load_word(2'd0, {$urandom, $urandom}, 0, 1);
        for (int k = 0; k < 10; k++) rand_vec(4'($urandom), "R2 new word after commit");

        // R9: overlong load into B, others unchanged
        load_word(2'd1, {$urandom, $urandom}, 7, 0);
        for (int k = 0; k < 20; k++) rand_vec(4'($urandom), "R9 last 64 bits and neighbours kept");

        // R6 R7: 256-entry function, full sweep against big truth table
        big = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        for (int t = 0; t < 4; t++) load_word(2'(t), big[t*64 +: 64], 0, 0);
        for (int idx = 0; idx < 256; idx++) begin
            logic [7:0] ix;
            exp_t e;
            ix = 8'(idx);
            @(negedge clk);
            lut_in = {4{ix[5:0]}}; mode_dual = 4'b0000;
            f7_sel = {2{ix[6]}}; f8_sel = ix[7];
            e = model();
            e.f8    = big[ix];
            e.f7[0] = big[{1'b0, ix[6:0]}];
            e.f7[1] = big[{1'b1, ix[6:0]}];
            e.req   = "R6 R7 wide function sweep";
            q.push_back(e);
        end

        repeat (3) @(negedge clk);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end
endmodule